// File: doc/BRIEF.md
# SPI Command Engine for a Time-to-Digital Converter

This block is an SPI master that runs one command per chip-select window against a time-to-digital converter. A requester hands it a command kind (power-on reset, initialise, register write or register read), a 4-bit register address, 32 bits of write data and a read-length flag. The engine builds the frame, lowers chip select, clocks the frame out MSB first, captures the reply for reads, raises chip select and reports completion.

The request side is a valid/ready stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a requester that holds `req_valid` simply waits. Nothing is queued. The engine has no skid buffer, and request fields are sampled only on the transfer edge.

The response side has no back-pressure. `rsp_valid` pulses for one cycle per command, and `rsp_rdata` keeps its value until the next request transfers. All chip-select timing margins are set by parameters in system-clock cycles. `HALF_CYC` sets each SCK phase; the default of 3 gives a 60 ns SCK at 100 MHz.

Top module: `tdc_spi_cmd`

## Requirements
- R1: While reset is asserted and after it is released, `spi_ssn` is 1, `spi_sck` is 0, `spi_mosi` is 0, `rsp_valid` is 0 and `req_ready` is 1. `tdc_rst_n` is 1 at all times.
- R2: Kind 0 (power-on reset) sends the single byte 0x50. Kind 1 (initialise) sends the single byte 0x70. Each produces exactly 8 SCK pulses, and the address and write data are ignored.
- R3: Kind 2 (write) sends opcode 0x80 OR the 4-bit address, followed by the 32 write-data bits. Both are sent MSB first, for 40 SCK pulses in total.
- R4: Kind 3 (read) sends opcode 0xB0 OR the address, then clocks 32 bits (`req_rd32`=1) or 16 bits (`req_rd32`=0) from MISO, MSB first, with MOSI held at 0. MISO is ignored during the opcode. The result is right-aligned in `rsp_rdata`, and the unused upper bits are 0.
- R5: SCK idles low. Each SCK high phase and each low phase between pulses lasts `HALF_CYC` cycles. MOSI changes only at an SCK rising edge and is stable while SCK is high. MISO is sampled at the SCK falling edge.
- R6: `spi_ssn` is low only during a transaction, and SCK never goes high while `spi_ssn` is high.
- R7: At least `SETUP_CYC` cycles pass from `spi_ssn` falling to the first SCK rise.
- R8: At least `HOLD_CYC` cycles pass from the last SCK fall to `spi_ssn` rising.
- R9: `spi_ssn` stays high for at least `GAP_CYC` cycles before it falls again.
- R10: A request starts a transaction only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that transfer until the gap has elapsed. A request asserted only while busy has no effect.
- R11: `rsp_valid` is a single-cycle pulse, once per command, on the cycle `spi_ssn` returns high. The read result stays on `rsp_rdata` until the next request transfers.
- R12: An asynchronous reset in mid-transaction returns the outputs to the idle values of R1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_kind | input | 2 | 0 power-on reset, 1 initialise, 2 write, 3 read |
| req_addr | input | 4 | Register address for write and read |
| req_wdata | input | 32 | Data for a register write |
| req_rd32 | input | 1 | Read length: 1 gives 32 bits, 0 gives 16 bits |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, right-aligned |
| spi_ssn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| tdc_rst_n | output | 1 | Converter reset pin, held high |

## Verification
The bench drives MISO high during the opcode of each read. A design that captured too early would then leak ones into the result, and a 16-bit read would show nonzero upper bits. Commands are issued back to back with `req_valid` held high, so a design that released `req_ready` early or skipped the idle gap would produce a chip-select high time shorter than `GAP_CYC`. The bench pulses a request only while a transaction is running; a design that took it would produce a second chip-select window. A reset in the middle of a write must leave SCK and MOSI low at once, not finish the frame.

// File: rtl/tdc_spi_pkg.sv
package tdc_spi_pkg;
  localparam int OP_W    = 8;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int FRAME_W = OP_W + DATA_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    CMD_POR   = 2'd0,
    CMD_INIT  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } eng_state_e;

  // Opcode byte; the address fills the low nibble for register access.
  function automatic logic [OP_W-1:0] opcode_for(cmd_kind_e k, logic [ADDR_W-1:0] a);
    case (k)
      CMD_POR:   return 8'h50;
      CMD_INIT:  return 8'h70;
      CMD_WRITE: return {4'h8, a};
      default:   return {4'hB, a};
    endcase
  endfunction

  // Total SCK pulses for one command.
  function automatic logic [BIT_W-1:0] frame_bits(cmd_kind_e k, logic long_rd);
    case (k)
      CMD_WRITE: return BIT_W'(FRAME_W);
      CMD_READ:  return long_rd ? BIT_W'(OP_W + 32) : BIT_W'(OP_W + 16);
      default:   return BIT_W'(OP_W);
    endcase
  endfunction
endpackage

// File: rtl/tdc_spi_sck_gen.sv
module tdc_spi_sck_gen #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb,
  output logic bit_end
);
  localparam int PER  = 2 * HALF_CYC;
  localparam int PH_W = $clog2(PER);

  logic [PH_W-1:0] ph;

  // Strobes mark the edge on which SCK changes.
  assign rise_stb = run && (ph == '0);
  assign fall_stb = run && (ph == PH_W'(HALF_CYC));
  assign bit_end  = run && (ph == PH_W'(PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      ph  <= '0;
      sck <= 1'b0;
    end else begin
      ph <= bit_end ? '0 : ph + 1'b1;
      if (rise_stb)      sck <= 1'b1;
      else if (fall_stb) sck <= 1'b0;
    end
  end
endmodule

// File: rtl/tdc_spi_shifter.sv
module tdc_spi_shifter #(
  parameter int FRAME_W = 40,
  parameter int RX_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic               shift_out,
  input  logic               capture,
  input  logic               quiet,
  input  logic               miso,
  output logic               mosi,
  output logic [RX_W-1:0]    rx_data
);
  logic [FRAME_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= '0;
      mosi    <= 1'b0;
      rx_data <= '0;
    end else if (load) begin
      tx      <= load_frame;
      mosi    <= 1'b0;
      rx_data <= '0;
    end else begin
      if (shift_out) begin
        mosi <= tx[FRAME_W-1];
        tx   <= {tx[FRAME_W-2:0], 1'b0};
      end else if (quiet) begin
        mosi <= 1'b0;
      end
      if (capture) rx_data <= {rx_data[RX_W-2:0], miso};
    end
  end
endmodule

// File: rtl/tdc_spi_cmd.sv
module tdc_spi_cmd
  import tdc_spi_pkg::*;
#(
  parameter int HALF_CYC  = 3,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 4,
  parameter int GAP_CYC   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_rd32,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        spi_ssn,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        tdc_rst_n
);
  localparam int TMAX_A = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int TMAX   = (TMAX_A > GAP_CYC) ? TMAX_A : GAP_CYC;
  localparam int CNT_W  = $clog2(TMAX + 1);

  eng_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_idx, nbits;
  logic               is_read, ssn_q, done_q;
  cmd_kind_e          kind_in;
  logic [FRAME_W-1:0] load_frame;
  logic               accept, run, last_bit, hold_done, capture;
  logic               rise_stb, fall_stb, bit_end;

  // Converter reset is issued over the serial link, so the pin stays high.
  assign tdc_rst_n = 1'b1;

  assign kind_in    = cmd_kind_e'(req_kind);
  assign load_frame = {opcode_for(kind_in, req_addr),
                       (kind_in == CMD_WRITE) ? req_wdata : {DATA_W{1'b0}}};
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign run        = (state == ST_SHIFT);
  assign last_bit   = (bit_idx == nbits - 1'b1);
  assign hold_done  = (state == ST_HOLD) && (cnt == CNT_W'(HOLD_CYC - 1));
  assign capture    = fall_stb && is_read && (bit_idx >= BIT_W'(OP_W));
  assign spi_ssn    = ssn_q;
  assign rsp_valid  = done_q;

  tdc_spi_sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sck      (spi_sck),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .bit_end  (bit_end)
  );

  tdc_spi_shifter #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_frame (load_frame),
    .shift_out  (rise_stb),
    .capture    (capture),
    .quiet      (hold_done),
    .miso       (spi_miso),
    .mosi       (spi_mosi),
    .rx_data    (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      nbits   <= '0;
      is_read <= 1'b0;
      ssn_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ssn_q   <= 1'b0;
          nbits   <= frame_bits(kind_in, req_rd32);
          is_read <= (kind_in == CMD_READ);
          bit_idx <= '0;
          cnt     <= '0;
          state   <= ST_SETUP;
        end
        ST_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          cnt   <= '0;
          state <= ST_SHIFT;
        end else cnt <= cnt + 1'b1;
        ST_SHIFT: if (bit_end) begin
          if (last_bit) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end else bit_idx <= bit_idx + 1'b1;
        end
        ST_HOLD: if (hold_done) begin
          ssn_q  <= 1'b1;
          done_q <= 1'b1;
          cnt    <= '0;
          state  <= ST_GAP;
        end else cnt <= cnt + 1'b1;
        ST_GAP: if (cnt == CNT_W'(GAP_CYC - 1)) begin
          cnt   <= '0;
          state <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checks
  logic [CNT_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= CNT_W'(GAP_CYC);
    else if (!spi_ssn)                  hi_cnt <= '0;
    else if (hi_cnt != CNT_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_sck_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ssn |-> !spi_sck);
  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_start_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ssn) |-> $past(req_valid && req_ready));
  assert_gap_met_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ssn) |-> (hi_cnt >= CNT_W'(GAP_CYC)));
endmodule

// File: tb/sim_tdc_spi_cmd.sv
module sim_tdc_spi_cmd;
  localparam int HALF = 3, SETUP = 1, HOLD = 4, GAP = 5;
  localparam int NV = 7;
  // {kind[2], addr[4], wdata[32], rd32[1], miso pattern[32]}
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 4'h5, 32'h1234_5678, 1'b0, 32'h0000_0000},
    {2'd1, 4'hA, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
    {2'd2, 4'h1, 32'hFA4C_02AA, 1'b0, 32'h0000_0000},
    {2'd3, 4'h5, 32'h0000_0000, 1'b0, 32'hDEAD_C3A5},
    {2'd3, 4'hF, 32'h0000_0000, 1'b1, 32'h8001_7FFE},
    {2'd2, 4'h0, 32'h0000_0001, 1'b0, 32'h0000_0000},
    {2'd2, 4'hE, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd32 = 1'b0, spi_miso = 1'b1;
  logic [1:0] req_kind = '0;
  logic [3:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, spi_ssn, spi_sck, spi_mosi, tdc_rst_n;
  logic [31:0] rsp_rdata;
  longint cyc = 0, prev_rise = -1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdc_spi_cmd #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata), .req_rd32(req_rd32),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .spi_ssn(spi_ssn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tdc_rst_n(tdc_rst_n));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [7:0] exp_op(input logic [1:0] k, input logic [3:0] a);
    case (k)
      2'd0: return 8'h50;
      2'd1: return 8'h70;
      2'd2: return 8'h80 | {4'h0, a};
      default: return 8'hB0 | {4'h0, a};
    endcase
  endfunction

  // Called at a falling clock edge; returns one sample after the done pulse.
  task automatic run_cmd(input logic [1:0] k, input logic [3:0] a, input logic [31:0] wd,
                         input logic r32, input logic [31:0] pat);
    int nb, len, rises, bad_half, bad_mosi, bad_gate, busy_rdy, dones, guard;
    logic [63:0] exp_frame, cap, mask;
    longint t_ssn_fall, t_first_rise, t_rise, t_last_fall, t_ssn_rise;
    logic prev_sck, prev_mosi;
    logic [31:0] got;
    len = r32 ? 32 : 16;
    case (k)
      2'd2:    begin nb = 40; exp_frame = {24'h0, exp_op(k, a), wd}; end
      2'd3:    begin nb = 8 + len; exp_frame = {48'h0, exp_op(k, a), 8'h0} << (len - 8); end
      default: begin nb = 8; exp_frame = {56'h0, exp_op(k, a)}; end
    endcase
    rises = 0; bad_half = 0; bad_mosi = 0; bad_gate = 0; busy_rdy = 0; dones = 0; guard = 0;
    cap = '0; t_first_rise = 0; t_rise = 0; t_last_fall = 0; t_ssn_rise = 0; got = '0;
    req_kind = k; req_addr = a; req_wdata = wd; req_rd32 = r32; req_valid = 1'b1;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    t_ssn_fall = cyc;
    check(spi_ssn == 1'b0, "R10 transfer lowers ssn", {63'h0, spi_ssn}, 64'h0);
    if (prev_rise >= 0)
      check(t_ssn_fall - prev_rise >= GAP, "R9 ssn high gap", t_ssn_fall - prev_rise, GAP);
    prev_sck = 1'b0; prev_mosi = spi_mosi; guard = 0;
    while (dones == 0 && guard < 1000) begin
      if (!spi_ssn && req_ready) busy_rdy++;
      if (spi_sck && spi_ssn) bad_gate++;
      if (spi_sck && prev_sck && spi_mosi != prev_mosi) bad_mosi++;
      if (spi_sck && !prev_sck) begin
        rises++;
        t_rise = cyc;
        if (rises == 1) t_first_rise = cyc;
        if (k == 2'd3 && rises > 8) spi_miso = pat[len - 1 - (rises - 9)];
      end
      if (!spi_sck && prev_sck) begin
        cap = {cap[62:0], spi_mosi};
        t_last_fall = cyc;
        if (cyc - t_rise != HALF) bad_half++;
        if (rises < nb) spi_miso = 1'b1;
      end
      if (spi_sck && !prev_sck && rises > 1 && (cyc - t_last_fall != HALF)) bad_half++;
      if (rsp_valid) begin
        dones++;
        t_ssn_rise = cyc;
        got = rsp_rdata;
        check(spi_ssn == 1'b1, "R11 done with ssn high", {63'h0, spi_ssn}, 64'h1);
      end
      prev_sck = spi_sck; prev_mosi = spi_mosi;
      @(negedge clk); guard++;
    end
    spi_miso = 1'b1;
    check(rsp_valid == 1'b0, "R11 done lasts one cycle", {63'h0, rsp_valid}, 64'h0);
    check(dones == 1, "R11 one done per command", dones, 1);
    check(rises == nb, "R2/R3/R4 sck pulse count", rises, nb);
    check(cap == exp_frame, "R3 R4 R2 mosi frame", cap, exp_frame);
    check(t_first_rise - t_ssn_fall >= SETUP, "R7 ssn setup", t_first_rise - t_ssn_fall, SETUP);
    check(t_ssn_rise - t_last_fall >= HOLD, "R8 ssn hold", t_ssn_rise - t_last_fall, HOLD);
    check(bad_half == 0, "R5 sck phase length", bad_half, 0);
    check(bad_mosi == 0, "R5 mosi stable while sck high", bad_mosi, 0);
    check(bad_gate == 0, "R6 sck only under ssn low", bad_gate, 0);
    check(busy_rdy == 0, "R10 ready low while busy", busy_rdy, 0);
    check(spi_mosi == 1'b0, "R4 mosi low after frame", {63'h0, spi_mosi}, 64'h0);
    if (k == 2'd3) begin
      mask = r32 ? 64'hFFFF_FFFF : 64'h0000_FFFF;
      check({32'h0, got} == ({32'h0, pat} & mask), "R4 read data", {32'h0, got}, {32'h0, pat} & mask);
    end
    prev_rise = t_ssn_rise;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lows, pulses;
    logic [31:0] held;
    logic prev_s;
    repeat (3) @(negedge clk);
    check(spi_ssn == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 idle lines in reset",
          {61'h0, spi_ssn, spi_sck, spi_mosi}, 64'h4);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake in reset",
          {62'h0, req_ready, rsp_valid}, 64'h2);
    check(tdc_rst_n == 1'b1, "R1 converter reset pin high", {63'h0, tdc_rst_n}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_ssn == 1'b1 && spi_sck == 1'b0 && req_ready == 1'b1, "R1 idle after reset",
          {61'h0, spi_ssn, spi_sck, req_ready}, 64'h5);

    for (int i = 0; i < NV; i++)
      run_cmd(VEC[i][70:69], VEC[i][68:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0]);

    // R11: read result held until the next transfer
    run_cmd(2'd3, 4'h2, 32'h0, 1'b1, 32'h5A5A_0FF0);
    held = rsp_rdata;
    repeat (8) @(negedge clk);
    check(rsp_rdata == held && held == 32'h5A5A_0FF0, "R11 read data held", {32'h0, rsp_rdata}, 64'h5A5A_0FF0);

    // R10: a request offered only while busy is not taken
    req_kind = 2'd1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_kind = 2'd2; req_wdata = 32'hFFFF_FFFF; req_valid = 1'b1;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    pulses = 0; lows = 0; prev_s = spi_sck;
    while (!rsp_valid) begin
      if (spi_sck && !prev_s) pulses++;
      prev_s = spi_sck;
      @(negedge clk);
    end
    repeat (40) begin
      @(negedge clk);
      if (!spi_ssn) lows++;
      if (spi_sck && !prev_s) pulses++;
      prev_s = spi_sck;
    end
    check(lows == 0, "R10 busy request ignored", lows, 0);
    check(pulses <= 8, "R10 no extra frame", pulses, 8);

    // R12: reset during a write
    req_kind = 2'd2; req_addr = 4'h3; req_wdata = 32'hFFFF_FFFF; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(spi_ssn == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0 && req_ready == 1'b1,
          "R12 reset mid-transfer", {60'h0, spi_ssn, spi_sck, spi_mosi, req_ready}, 64'h9);
    @(negedge clk);
    rst_n = 1'b1;
    prev_rise = -1;
    @(negedge clk);
    run_cmd(2'd0, 4'h0, 32'h0, 1'b0, 32'h0);

    summary();
    $finish;
  end
endmodule